// File: doc/BRIEF.md
# Frame-Counter Video Timing Generator

This block is the timing engine of a panel output. Software programs the line period, sync pulse widths, the horizontal active range and the vertical positions through a small register write port, then switches the engine on. Two counters run on the pixel clock. A line counter gives the horizontal position. A frame-wide counter gives every vertical event as an absolute pixel-clock position inside the frame, not as a line number. This means vertical sync, the start and end of the active window, and a fetch-start strobe for the upstream pixel pipeline can each land on any pixel of any line. A horizontal skew can be added to the vertical positions.

The upstream pipeline delivers pixels over a valid/ready stream. Ready is high exactly during the data-enable window, and the block holds no buffer. A pixel transfers on every cycle where valid and ready are both high. If ready is high and valid is low, the stream has underflowed. The block then drives a programmable underflow colour and sets a sticky flag that software clears by writing 1. Outside the window the pixel output is zero.

All timing registers pass through shadow copies. While the engine is stopped, the copies follow the registers. While it runs, they are reloaded only on the last pixel clock of a frame, so one frame never mixes two timings.

Top module: `tg_top`

## Requirements
- R1: After reset, hsync, vsync, de, fetch_start, pix_ready, pix_out and uf_sticky are all 0.
- R2: Writing 1 to bit 0 of address 9 starts both counters from zero, and the cycle after the write edge shows frame position 0. Writing 0 stops them and holds all timing outputs and pix_out at 0.
- R3: Address 0 holds the line period in bits 31:16 and the hsync width in bits 15:0. The line position runs from 0 to period−1 and wraps, and it also returns to 0 when the frame wraps. hsync is high while the line position is below the width.
- R4: Address 1 holds the frame length in pixel clocks, and the frame position wraps after length−1. Address 2 holds the vsync width in pixel clocks, and vsync is high while the frame position is below it.
- R5: Address 3 holds the last active x in bits 31:16 and the first active x in bits 15:0. Addresses 4 and 5 hold the first and last active frame positions. de is high only when both positions lie inside their inclusive ranges.
- R6: fetch_start is high for the single cycle in which the frame position equals address 6, and only while bit 31 of address 7 is 1.
- R7: pix_ready equals de. When de and pix_valid are both high, pix_out equals pix_data. Outside de, pix_out is 0.
- R8: When de is high and pix_valid is low, pix_out equals the underflow colour held in bits 23:0 of address 8.
- R9: uf_sticky is set on the edge after any cycle with de high and pix_valid low. Writing 1 to bit 0 of address 10 clears it, and a set in the same cycle wins. It stays 0 if no underflow occurs.
- R10: A register write made while the engine runs takes effect from the first cycle of the next frame. The current frame finishes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream pixel valid |
| pix_ready | output | 1 | Pixel accepted this cycle when valid (equals de) |
| pix_data | input | 24 | Upstream pixel value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active data window |
| fetch_start | output | 1 | One-cycle fetch strobe for the upstream pipeline |
| pix_out | output | 24 | Pixel driven to the panel |
| uf_sticky | output | 1 | Sticky underflow flag |

## Verification
The checker watches, on every cycle, that a stopped engine drives no timing, that the frame position only steps by one or returns to zero, that the line position is zero whenever the frame position is, and that pixel substitution and the sticky set follow valid and de. Only the bench scenarios can show that the whole waveform matches the programmed values. These cover full frames with and without fetch, a skewed vertical window, a sustained underflow with its clear, and a mid-frame reprogramming whose effect must wait for the next frame.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int LINE_W  = 16;
  localparam int FRAME_W = 24;
  localparam int PIX_W   = 24;
  localparam int FETCH_EN_BIT = 31;

  localparam logic [ADDR_W-1:0] A_HCTL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FLEN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_VPULSE = 4'd2;
  localparam logic [ADDR_W-1:0] A_XWIN   = 4'd3;
  localparam logic [ADDR_W-1:0] A_VSTART = 4'd4;
  localparam logic [ADDR_W-1:0] A_VEND   = 4'd5;
  localparam logic [ADDR_W-1:0] A_FSTART = 4'd6;
  localparam logic [ADDR_W-1:0] A_CFG    = 4'd7;
  localparam logic [ADDR_W-1:0] A_UFCOL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RUN    = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd10;

  typedef struct packed {
    logic [LINE_W-1:0]  period;
    logic [LINE_W-1:0]  hwidth;
    logic [LINE_W-1:0]  last_x;
    logic [LINE_W-1:0]  first_x;
    logic [FRAME_W-1:0] flen;
    logic [FRAME_W-1:0] vpulse;
    logic [FRAME_W-1:0] vstart;
    logic [FRAME_W-1:0] vend;
    logic [FRAME_W-1:0] fstart;
    logic               fetch_en;
  } timing_t;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W,
  parameter int PW = PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic          frame_end,
  output timing_t       shd,
  output logic          run,
  output logic [PW-1:0] uf_colour,
  output logic          sticky_clr
);
  localparam int HALF = RW / 2;

  timing_t cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      run       <= 1'b0;
      uf_colour <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HCTL:   begin cur.period <= wr_data[RW-1:HALF]; cur.hwidth <= wr_data[HALF-1:0]; end
        A_FLEN:   cur.flen   <= wr_data[FRAME_W-1:0];
        A_VPULSE: cur.vpulse <= wr_data[FRAME_W-1:0];
        A_XWIN:   begin cur.last_x <= wr_data[RW-1:HALF]; cur.first_x <= wr_data[HALF-1:0]; end
        A_VSTART: cur.vstart <= wr_data[FRAME_W-1:0];
        A_VEND:   cur.vend   <= wr_data[FRAME_W-1:0];
        A_FSTART: cur.fstart <= wr_data[FRAME_W-1:0];
        A_CFG:    cur.fetch_en <= wr_data[FETCH_EN_BIT];
        A_UFCOL:  uf_colour <= wr_data[PW-1:0];
        A_RUN:    run <= wr_data[0];
        default:  ;
      endcase
    end
  end

  // Shadow copy follows while stopped, reloads only at frame end while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shd <= '0;
    else if (!run || frame_end) shd <= cur;
  end

  assign sticky_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
endmodule

// File: rtl/tg_counters.sv
module tg_counters #(
  parameter int LW = tg_pkg::LINE_W,
  parameter int FW = tg_pkg::FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] period,
  input  logic [FW-1:0] flen,
  output logic [LW-1:0] lc,
  output logic [FW-1:0] fc,
  output logic          frame_end
);
  localparam logic [LW-1:0] LONE = LW'(1);
  localparam logic [FW-1:0] FONE = FW'(1);

  assign frame_end = run && (fc >= flen - FONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc <= '0;
      lc <= '0;
    end else if (!run || frame_end) begin
      fc <= '0;
      lc <= '0;
    end else begin
      fc <= fc + FONE;
      lc <= (lc >= period - LONE) ? '0 : lc + LONE;
    end
  end
endmodule

// File: rtl/tg_decode.sv
module tg_decode #(
  parameter int LW = tg_pkg::LINE_W,
  parameter int FW = tg_pkg::FRAME_W
) (
  input  logic          run,
  input  logic [LW-1:0] lc,
  input  logic [FW-1:0] fc,
  input  logic [LW-1:0] hwidth,
  input  logic [LW-1:0] first_x,
  input  logic [LW-1:0] last_x,
  input  logic [FW-1:0] vpulse,
  input  logic [FW-1:0] vstart,
  input  logic [FW-1:0] vend,
  input  logic [FW-1:0] fstart,
  input  logic          fetch_en,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          fetch_start
);
  logic in_x, in_v;

  always_comb begin
    in_x        = (lc >= first_x) && (lc <= last_x);
    in_v        = (fc >= vstart) && (fc <= vend);
    hsync       = run && (lc < hwidth);
    vsync       = run && (fc < vpulse);
    de          = run && in_x && in_v;
    fetch_start = run && fetch_en && (fc == fstart);
  end
endmodule

// File: rtl/tg_pixel.sv
module tg_pixel #(
  parameter int PW = tg_pkg::PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  input  logic [PW-1:0] uf_colour,
  input  logic          sticky_clr,
  output logic [PW-1:0] pix_out,
  output logic          uf_sticky
);
  logic starved;

  always_comb begin
    starved = de && !pix_valid;
    if (!de)          pix_out = '0;
    else if (starved) pix_out = uf_colour;
    else              pix_out = pix_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uf_sticky <= 1'b0;
    else if (starved)    uf_sticky <= 1'b1;
    else if (sticky_clr) uf_sticky <= 1'b0;
  end
endmodule

// File: rtl/tg_top.sv
module tg_top
  import tg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [PIX_W-1:0]   pix_data,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               fetch_start,
  output logic [PIX_W-1:0]   pix_out,
  output logic               uf_sticky
);
  timing_t              shd;
  logic                 run;
  logic                 frame_end;
  logic                 sticky_clr;
  logic [PIX_W-1:0]     uf_colour;
  logic [LINE_W-1:0]    lc;
  logic [FRAME_W-1:0]   fc;

  tg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_end(frame_end), .shd(shd), .run(run), .uf_colour(uf_colour),
    .sticky_clr(sticky_clr)
  );

  tg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .period(shd.period), .flen(shd.flen),
    .lc(lc), .fc(fc), .frame_end(frame_end)
  );

  tg_decode u_dec (
    .run(run), .lc(lc), .fc(fc), .hwidth(shd.hwidth), .first_x(shd.first_x),
    .last_x(shd.last_x), .vpulse(shd.vpulse), .vstart(shd.vstart), .vend(shd.vend),
    .fstart(shd.fstart), .fetch_en(shd.fetch_en), .hsync(hsync), .vsync(vsync),
    .de(de), .fetch_start(fetch_start)
  );

  tg_pixel u_pix (
    .clk(clk), .rst_n(rst_n), .de(de), .pix_valid(pix_valid), .pix_data(pix_data),
    .uf_colour(uf_colour), .sticky_clr(sticky_clr), .pix_out(pix_out),
    .uf_sticky(uf_sticky)
  );

  assign pix_ready = de;
endmodule

// File: rtl/tg_chk.sv
module tg_chk #(
  parameter int LW = tg_pkg::LINE_W,
  parameter int FW = tg_pkg::FRAME_W,
  parameter int PW = tg_pkg::PIX_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [LW-1:0] lc,
  input logic [FW-1:0] fc,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          fetch_start,
  input logic          pix_valid,
  input logic [PW-1:0] pix_data,
  input logic [PW-1:0] pix_out,
  input logic [PW-1:0] uf_colour,
  input logic          uf_sticky
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hsync && !vsync && !de && !fetch_start && pix_out == '0)); // R2
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && fc != '0) |-> (fc == $past(fc) + 1'b1)); // R4
  AST_LINE_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == '0) |-> (lc == '0)); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (de && pix_valid) |-> (pix_out == pix_data)); // R7
  AST_UF_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !pix_valid) |-> (pix_out == uf_colour)); // R8
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !pix_valid) |=> uf_sticky); // R9
endmodule

bind tg_top tg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .lc(lc), .fc(fc), .hsync(hsync),
  .vsync(vsync), .de(de), .fetch_start(fetch_start), .pix_valid(pix_valid),
  .pix_data(pix_data), .pix_out(pix_out), .uf_colour(uf_colour), .uf_sticky(uf_sticky)
);

// File: tb/sim_tg_top.sv
`timescale 1ns/1ps
module sim_tg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic        hsync, vsync, de, fetch_start, uf_sticky;
  logic [23:0] pix_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tg_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .fetch_start(fetch_start),
    .pix_out(pix_out), .uf_sticky(uf_sticky)
  );

  typedef struct {
    int period, hw, fx, lx, flen, vp, vs, ve, fs;
    bit fen;
  } tparams_t;

  typedef struct {
    bit          hs, vs, de, fe;
    logic [23:0] pix;
    bit          valid;
    bit          shd;
    int          pos;
  } item_t;

  item_t sb[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle while the scoreboard holds items
  always begin
    item_t it;
    string pre;
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      it  = sb.pop_front();
      pre = it.shd ? "R10" : "";
      check(hsync == it.hs, {pre, " R3"}, $sformatf("hsync@%0d", it.pos), hsync, it.hs);
      check(vsync == it.vs, {pre, " R4"}, $sformatf("vsync@%0d", it.pos), vsync, it.vs);
      check(de == it.de, {pre, " R5"}, $sformatf("de@%0d", it.pos), de, it.de);
      check(fetch_start == it.fe, {pre, " R6"}, $sformatf("fetch@%0d", it.pos), fetch_start, it.fe);
      check(pix_ready == it.de, {pre, " R7"}, $sformatf("ready@%0d", it.pos), pix_ready, it.de);
      check(pix_out == it.pix, it.valid ? {pre, " R7"} : {pre, " R8"},
            $sformatf("pix@%0d", it.pos), pix_out, it.pix);
    end
  end

  // Driver side: expected items computed from the requirement formulas
  task automatic push_frame(tparams_t p, bit valid, logic [23:0] data, logic [23:0] uf, bit shd);
    for (int f = 0; f < p.flen; f++) begin
      item_t it;
      int l;
      l        = f % p.period;
      it.hs    = (l < p.hw);
      it.vs    = (f < p.vp);
      it.de    = (f >= p.vs) && (f <= p.ve) && (l >= p.fx) && (l <= p.lx);
      it.fe    = p.fen && (f == p.fs);
      it.pix   = it.de ? (valid ? data : uf) : 24'h0;
      it.valid = valid;
      it.shd   = shd;
      it.pos   = f;
      sb.push_back(it);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(tparams_t p);
    wr(4'd0, {p.period[15:0], p.hw[15:0]});
    wr(4'd1, p.flen);
    wr(4'd2, p.vp);
    wr(4'd3, {p.lx[15:0], p.fx[15:0]});
    wr(4'd4, p.vs);
    wr(4'd5, p.ve);
    wr(4'd6, p.fs);
    wr(4'd7, {p.fen, 31'd0});
  endtask

  // R2: enable written at a negedge; expected items pushed before the next sample
  task automatic start_with(tparams_t a, int na, bit valid, logic [23:0] data, logic [23:0] uf);
    @(negedge clk);
    pix_valid = valid; pix_data = data;
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'd1;
    for (int i = 0; i < na; i++) push_frame(a, valid, data, uf, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic check_idle(string req);
    @(posedge clk); #1;
    check(!hsync && !vsync && !de && !fetch_start && pix_out == 24'h0 && !pix_ready,
          req, "idle outputs", {hsync, vsync, de, fetch_start, pix_ready}, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    tparams_t p1, p2, p3;
    p1 = '{period:10, hw:2, fx:4, lx:7, flen:80, vp:10, vs:30, ve:59, fs:61, fen:1'b1};
    p2 = '{period:10, hw:2, fx:4, lx:7, flen:80, vp:10, vs:33, ve:62, fs:61, fen:1'b0};
    p3 = '{period:8,  hw:1, fx:3, lx:6, flen:64, vp:8,  vs:24, ve:47, fs:49, fen:1'b1};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(posedge clk); #1;
    check(!hsync && !vsync && !de && !fetch_start && !pix_ready && pix_out == 0,
          "R1", "timing outputs after reset", {hsync, vsync, de, fetch_start, pix_ready}, 0);
    check(!uf_sticky, "R1", "uf_sticky after reset", uf_sticky, 0);

    // Scenario 1: two frames, valid stream, fetch enabled
    prog(p1);
    wr(4'd8, 32'h0000FF);
    start_with(p1, 2, 1'b1, 24'hA5A5A5, 24'h0000FF);
    drain();
    wr(4'd9, 32'd0);
    check_idle("R2");
    check(!uf_sticky, "R9", "no underflow leaves sticky clear", uf_sticky, 0);

    // Scenario 2: skewed vertical window, fetch disabled, starved stream
    prog(p2);
    wr(4'd8, 32'h00C0DE);
    start_with(p2, 1, 1'b0, 24'h123456, 24'h00C0DE);
    drain();
    wr(4'd9, 32'd0);
    check_idle("R2");
    @(posedge clk); #1;
    check(uf_sticky, "R9", "sticky after underflow", uf_sticky, 1);
    wr(4'd10, 32'd1);
    @(posedge clk); #1;
    check(!uf_sticky, "R9", "sticky after write-one clear", uf_sticky, 0);

    // Scenario 3: reprogram mid-frame; new timing from the next frame only
    prog(p1);
    wr(4'd8, 32'h0000FF);
    start_with(p1, 1, 1'b1, 24'h5A5A5A, 24'h0000FF);
    push_frame(p3, 1'b1, 24'h5A5A5A, 24'h0000FF, 1'b1);
    repeat (10) @(negedge clk);
    prog(p3);
    drain();
    wr(4'd9, 32'd0);
    check_idle("R2");
    check(!uf_sticky, "R9", "sticky stays clear with valid stream", uf_sticky, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule